// File: doc/BRIEF.md
# Flow-Through Synchronous Word Store with Lane Writes

This block is a synchronous on-chip word store whose read path is flow-through. At each rising clock edge it captures an address, the three chip-select inputs and the write controls. On a read, the word at the captured address reaches the data outputs within that same clock period, because no output register sits between the array and the pins. A write uses the data presented at the same edge as its address, so the caller never shapes a write strobe.

Writes have two forms. In a lane write, a lane-write qualifier is combined with per-lane select bits, and only the selected lanes change. A whole-word write input updates every lane and overrides both the qualifier and the selects. The bidirectional data bus is split into an input bus, an output bus and a drive enable. Two asynchronous inputs act on the drive enable directly: an output-enable and a sleep input. While sleep is high, clock edges start no access, and the stored contents are kept. The lane count and lane width are parameters, which cover the two-lane by nine, four-lane by eight and four-lane by nine organisations.

Top module: `ftsram`

## Requirements
- R1: A read cycle is a selected edge with no write requested. After that edge, within the same clock period, `dout` carries the word at the captured address and `dout_en` is high, provided `oe` is high and `sleep` is low. A word written at one edge can be read back at the next edge.
- R2: At a selected edge with `byte_wr_en` high, `glob_wr` low and at least one `byte_sel` bit set, the block writes lane i (data bits [i*BYTE_W +: BYTE_W]) only where `byte_sel[i]` is 1. Every other lane keeps its value.
- R3: When `byte_wr_en` and `glob_wr` are both low, `byte_sel` has no effect and the cycle is a read. When `byte_wr_en` is high and `byte_sel` is all zero, the cycle is also a read.
- R4: At a selected edge with `glob_wr` high, the block writes every lane from `din`, whatever `byte_wr_en` and `byte_sel` are.
- R5: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at the edge. Any other combination makes a deselect cycle: nothing is written and `dout_en` is low for that period.
- R6: During the period that follows a write edge, `dout_en` is low even with `oe` high.
- R7: `oe` acts without a clock. While `oe` is low, `dout_en` is low. When `oe` is raised again during a read period, the drive returns within that same period.
- R8: `sleep` acts without a clock. While it is high, `dout_en` is low. Edges that occur while it is high write nothing and end as deselect cycles. Stored words are unchanged when it is released.
- R9: A synchronous active-high `rst` makes the following period a deselect period with `dout_en` low. Reset does not clear the stored contents.
- R10: Whenever `dout_en` is low, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, captured at the edge |
| din | input | BYTES*BYTE_W | Write data, captured at the edge |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| glob_wr | input | 1 | Whole-word write, overrides lane controls |
| byte_wr_en | input | 1 | Lane-write qualifier |
| byte_sel | input | BYTES | Per-lane write select |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| dout | output | BYTES*BYTE_W | Read data, flow-through |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
Two functions can meet in the same edge: the whole-word write and the lane-write controls. The bench asserts `glob_wr` together with `byte_wr_en` and a partial `byte_sel`, reads the word back, and expects every lane to be replaced. Sleep can also meet a write request. The bench holds `sleep` high across edges that carry a full write with the chip selected, releases it, and expects the stored word to be unchanged. The asynchronous inputs are also changed in the middle of a read period, and the bench expects the drive to follow them without waiting for an edge.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;

    // Kind of access captured at a clock edge.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // The three selects must agree: low, high, low.
    function automatic logic chip_selected(input logic s1_n, input logic s2, input logic s3_n);
        return !s1_n && s2 && !s3_n;
    endfunction

endpackage

// File: rtl/ftsram_decode.sv
module ftsram_decode
    import ftsram_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             glob_wr,
    input  logic             byte_wr_en,
    input  logic [BYTES-1:0] byte_sel,
    input  logic             sleep,
    output cyc_e             kind,
    output logic [BYTES-1:0] lane_we
);

    logic [BYTES-1:0] req_mask;
    logic             live;

    always_comb begin
        if (glob_wr)
            req_mask = '1;
        else if (byte_wr_en)
            req_mask = byte_sel;
        else
            req_mask = '0;
    end

    assign live = chip_selected(cs1_n, cs2, cs3_n) && !sleep;

    always_comb begin
        if (!live)
            kind = CYC_IDLE;
        else if (|req_mask)
            kind = CYC_WRITE;
        else
            kind = CYC_READ;
    end

    assign lane_we = (kind == CYC_WRITE) ? req_mask : '0;

endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTES-1:0]        lane_we,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                cells[wr_addr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        // Unregistered read: the flow-through path.
        assign rdata[g*BYTE_W +: BYTE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/ftsram_drive.sv
module ftsram_drive
    import ftsram_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  cyc_e              kind_q,
    input  logic              oe,
    input  logic              sleep,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    assign dout_en = (kind_q == CYC_READ) && oe && !sleep;
    assign dout    = dout_en ? rdata : '0;

endmodule

// File: rtl/ftsram.sv
module ftsram
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] din,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    glob_wr,
    input  logic                    byte_wr_en,
    input  logic [BYTES-1:0]        byte_sel,
    input  logic                    oe,
    input  logic                    sleep,
    output logic [BYTES*BYTE_W-1:0] dout,
    output logic                    dout_en
);

    localparam int WORD_W = BYTES * BYTE_W;

    cyc_e              kind_d;
    cyc_e              kind_q;
    logic [BYTES-1:0]  lane_req;
    logic [BYTES-1:0]  lane_we;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] rdata;

    ftsram_decode #(.BYTES(BYTES)) u_decode (
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .glob_wr    (glob_wr),
        .byte_wr_en (byte_wr_en),
        .byte_sel   (byte_sel),
        .sleep      (sleep),
        .kind       (kind_d),
        .lane_we    (lane_req)
    );

    // A reset edge never writes.
    assign lane_we = rst ? '0 : lane_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= CYC_IDLE;
            addr_q <= '0;
        end else begin
            kind_q <= kind_d;
            addr_q <= addr;
        end
    end

    ftsram_array #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .wr_addr (addr),
        .lane_we (lane_we),
        .wdata   (din),
        .rd_addr (addr_q),
        .rdata   (rdata)
    );

    ftsram_drive #(.WORD_W(WORD_W)) u_drive (
        .kind_q  (kind_q),
        .oe      (oe),
        .sleep   (sleep),
        .rdata   (rdata),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk #(
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cs1_n,
    input logic                    cs2,
    input logic                    cs3_n,
    input logic                    glob_wr,
    input logic                    byte_wr_en,
    input logic [BYTES-1:0]        byte_sel,
    input logic                    oe,
    input logic                    sleep,
    input logic [BYTES*BYTE_W-1:0] dout,
    input logic                    dout_en
);

    logic sel_c;
    logic wr_c;
    logic rd_go;

    assign sel_c = !cs1_n && cs2 && !cs3_n;
    assign wr_c  = glob_wr || (byte_wr_en && (|byte_sel));
    assign rd_go = !rst && !sleep && sel_c && !wr_c;

    // R9
    reset_idle_chk: assert property (@(posedge clk) rst |=> !dout_en);

    // R5
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_c && !sleep) |=> !dout_en);

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_c && wr_c && !sleep) |=> !dout_en);

    // R1
    flow_read_chk: assert property (@(posedge clk) disable iff (rst)
        (oe && !sleep && $past(rd_go)) |-> dout_en);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !dout_en);

    // R8
    sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_en);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

endmodule

bind ftsram ftsram_chk #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .glob_wr    (glob_wr),
    .byte_wr_en (byte_wr_en),
    .byte_sel   (byte_sel),
    .oe         (oe),
    .sleep      (sleep),
    .dout       (dout),
    .dout_en    (dout_en)
);

// File: tb/tb_ftsram.sv
module tb_ftsram;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int WW = NB * BW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [WW-1:0] din;
    logic          cs1_n, cs2, cs3_n;
    logic          glob_wr, byte_wr_en;
    logic [NB-1:0] byte_sel;
    logic          oe, sleep;
    logic [WW-1:0] dout;
    logic          dout_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference state: 0 idle, 1 read, 2 write.
    int            exp_kind = 0;
    int            exp_addr = 0;
    logic [WW-1:0] ref_mem [int];

    always #4 clk = ~clk;

    ftsram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .glob_wr(glob_wr), .byte_wr_en(byte_wr_en), .byte_sel(byte_sel),
        .oe(oe), .sleep(sleep), .dout(dout), .dout_en(dout_en)
    );

    task automatic compare(input string tag);
        logic          e_en;
        logic [WW-1:0] e_d;
        e_en = (exp_kind == 1) && oe && !sleep;
        e_d  = e_en ? ref_mem[exp_addr] : '0;
        checks++;
        if (dout_en !== e_en || dout !== e_d) begin
            failures++;
            $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
                     tag, dout_en, dout, e_en, e_d);
        end
    endtask

    // Drive one edge's inputs, update the model, then sample mid-period.
    task automatic apply(input logic r, input logic [2:0] cs, input logic gw,
                         input logic bwe, input logic [NB-1:0] bs, input int a,
                         input logic [WW-1:0] d, input string tag);
        logic [NB-1:0] m;
        rst = r; {cs1_n, cs2, cs3_n} = cs; glob_wr = gw; byte_wr_en = bwe;
        byte_sel = bs; addr = AW'(a); din = d;
        if (r || sleep || cs != 3'b010) begin
            exp_kind = 0;
        end else begin
            m = gw ? '1 : (bwe ? bs : '0);
            if (m != '0) begin
                exp_kind = 2;
                if (!ref_mem.exists(a)) ref_mem[a] = '0;
                for (int i = 0; i < NB; i++)
                    if (m[i]) ref_mem[a][i*BW +: BW] = d[i*BW +: BW];
            end else begin
                exp_kind = 1;
                exp_addr = a;
            end
        end
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    localparam logic [2:0] SEL = 3'b010;

    initial begin
        rst = 1; oe = 1; sleep = 0;
        {cs1_n, cs2, cs3_n} = 3'b111; glob_wr = 0; byte_wr_en = 0;
        byte_sel = '0; addr = '0; din = '0;
        apply(1, SEL, 1, 0, '0, 1, 36'h111111111, "R9 reset");
        apply(1, SEL, 0, 0, '0, 1, '0, "R9 reset held");

        // R4: whole-word write, then flow-through read (R1).
        apply(0, SEL, 1, 0, '0, 5, 36'hA5A5A5A5A, "R6 write period undriven");
        apply(0, SEL, 0, 0, '0, 5, '0, "R1 read after whole write");

        // R2: lane writes.
        apply(0, SEL, 0, 1, 4'b1111, 6, 36'h123456789, "R2 all lanes");
        apply(0, SEL, 0, 1, 4'b0101, 6, 36'hFFFFFFFFF, "R2 lanes 0 and 2");
        apply(0, SEL, 0, 0, '0, 6, '0, "R2 merged read");
        apply(0, SEL, 0, 1, 4'b1000, 6, 36'h000000000, "R2 top lane");
        apply(0, SEL, 0, 0, '0, 6, '0, "R2 top lane read");

        // R3: selects ignored without qualifier.
        apply(0, SEL, 0, 0, 4'b1111, 6, 36'h0DEADBEEF, "R3 selects ignored");
        apply(0, SEL, 0, 1, 4'b0000, 6, 36'h0DEADBEEF, "R3 empty select reads");
        apply(0, SEL, 0, 0, '0, 6, '0, "R3 unchanged");

        // R4: whole-word write overrides partial lane controls.
        apply(0, SEL, 1, 1, 4'b0001, 6, 36'hCAFEF00D5, "R4 override write");
        apply(0, SEL, 0, 0, '0, 6, '0, "R4 all lanes replaced");

        // R5: each non-select combination writes nothing.
        apply(0, 3'b110, 1, 0, '0, 6, 36'h0, "R5 cs1_n high");
        apply(0, 3'b000, 1, 0, '0, 6, 36'h0, "R5 cs2 low");
        apply(0, 3'b011, 1, 0, '0, 6, 36'h0, "R5 cs3_n high");
        apply(0, 3'b011, 0, 0, '0, 6, 36'h0, "R5 deselect read undriven");
        apply(0, SEL, 0, 0, '0, 6, '0, "R5 contents kept");

        // R1: back-to-back reads of different words, read right after write.
        apply(0, SEL, 1, 0, '0, 200, 36'h876543210, "R6 write");
        apply(0, SEL, 0, 0, '0, 200, '0, "R1 read next edge");
        apply(0, SEL, 0, 0, '0, 5, '0, "R1 back to back");
        apply(0, SEL, 0, 0, '0, 6, '0, "R1 back to back 2");

        // R7: oe without clock.
        oe = 0; #1; compare("R7 oe low drops drive");
        checks++;
        if (dout !== '0) begin
            failures++;
            $display("FAIL R10: dout=%h expected 0", dout);
        end
        oe = 1; #1; compare("R7 oe high restores drive");

        // R8: sleep without clock, edges ignored, contents retained.
        sleep = 1; #1; compare("R8 sleep drops drive");
        apply(0, SEL, 1, 0, '0, 6, 36'h000000001, "R8 sleep edge");
        apply(0, SEL, 0, 1, 4'b1111, 5, 36'h000000002, "R8 sleep edge 2");
        sleep = 0; #1; compare("R8 idle after sleep");
        apply(0, SEL, 0, 0, '0, 6, '0, "R8 word 6 retained");
        apply(0, SEL, 0, 0, '0, 5, '0, "R8 word 5 retained");

        // R9: reset keeps contents.
        apply(1, SEL, 0, 0, '0, 5, '0, "R9 reset mid-run");
        apply(0, SEL, 0, 0, '0, 5, '0, "R9 contents survive reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule